// File: doc/BRIEF.md
# Watchdog Timer with Sticky Enable and Forced Reset

This block guards a processor against runaway software. Once enabled, it counts down toward a timeout, and software must rewrite its 8-bit control register before the countdown runs out. If no rewrite arrives in time, the block raises a one-cycle reset request for the system reset logic. The timeout is a seven-bit down-counter stepped by a fixed prescaler of `PRESCALE` clock cycles (12288 by default). The reset request fires when counter bit 6 drops from 1 to 0. A control byte of 0xC0 therefore gives the shortest interval, `PRESCALE` cycles. A control byte of 0xFF gives the longest, 64 × `PRESCALE` cycles.

Control byte layout:
- Bit 7 is the enable. It is sticky: only a system reset or the block's own reset request clears it.
- Bits 6:0 load the counter.

A write with bit 6 clear, made while the block is enabled or made together with bit 7 set, skips the countdown and requests a reset at once. Software can use this as a deliberate reset. A strap input selects hardware mode, in which the watchdog is already running when reset is released. A halt request trips the watchdog only while it runs and only when the halt permission strap is set.

The control is a three-state machine:
- State **IDLE** is disabled.
- State **RUN** counts down.
- State **FIRE** is the single cycle in which the reset request is driven.

The transitions are:
- **ARM**: IDLE → RUN, on a write with bit 7 and bit 6 set.
- **FORCE**: IDLE or RUN → FIRE, on a write with bit 6 clear, which from IDLE also needs bit 7 set.
- **REFRESH**: RUN → RUN, on a write with bit 6 set. It reloads the counter and clears the prescaler.
- **EXPIRE**: RUN → FIRE, when counter bit 6 falls.
- **HALT_TRIP**: RUN → FIRE, on a permitted halt request.
- **RELEASE**: FIRE → IDLE, in software mode.
- **REARM**: FIRE → RUN, in hardware mode.

Top module: `wdt_timer`

## Requirements
- R1: With `hw_mode` low, after reset the block is disabled: `wdg_active`=0, `wdg_rst`=0 and `ctrl_rd`=0x7F (bit 7 = enable, bits 6:0 = counter, counter reset value 0x7F).
- R2: A write with `wr_data[7]`=1 while disabled enables the watchdog. While it is enabled, a write with bit 7 = 0 leaves `ctrl_rd[7]` and `wdg_active` at 1.
- R3: After a write of a value with bit 6 set that enables or refreshes the watchdog, `wdg_rst` is first high exactly (`wr_data[5:0]`+1) × `PRESCALE` clock cycles after the write edge. `ctrl_rd[6:0]` shows the counter decrementing once every `PRESCALE` cycles.
- R4: Every write while enabled reloads the counter from `wr_data[6:0]` and restarts the prescaler, so periodic rewrites keep `wdg_rst` low.
- R5: A write with `wr_data[6]`=0, made while enabled or together with `wr_data[7]`=1, raises `wdg_rst` in the cycle right after the write edge (0x80 forces a reset).
- R6: `wdg_rst` is high for exactly one cycle per event.
- R7: After its own reset request, the block returns to `ctrl_rd[6:0]`=0x7F. With `hw_mode`=0 it is disabled. With `hw_mode`=1 it stays enabled and counts again.
- R8: With `hw_mode`=1 during reset, the block is enabled from reset release with `ctrl_rd`=0xFF and times out 64 × `PRESCALE` cycles later.
- R9: While enabled, `halt_req` with `halt_rst_en`=1 raises `wdg_rst` in the next cycle. With `halt_rst_en`=0, or while disabled, `halt_req` has no effect on `wdg_rst`.
- R10: While disabled, a write with bit 7 = 0 only loads the counter (visible on `ctrl_rd`). No countdown and no reset follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | Strap: watchdog runs from reset |
| halt_rst_en | input | 1 | Strap: a halt request while running causes a reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| halt_req | input | 1 | Processor is entering halt |
| ctrl_rd | output | 8 | Readback: {enable, counter[6:0]} |
| wdg_rst | output | 1 | One-cycle reset request |
| wdg_active | output | 1 | Watchdog is running |

## Verification
The countdown is exercised with a table of control values: the minimum 0xC0, two small intervals, a middle value and the maximum 0xFF. Each entry checks both that no request appears one cycle early and that one appears on the exact cycle, which separates an off-by-one in the prescaler from one in the counter. Directed cases follow:
- A rewrite sequence using bit-7-clear values tells sticky enable and refresh apart from a timeout.
- 0x80, written both while running and while disabled, tells FORCE apart from ARM.
- Halt requests under each strap setting check HALT_TRIP.
- A hardware-mode reset shows the REARM path, which differs from the RELEASE path taken in software mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Control byte geometry; bit positions carry behaviour (enable, trigger bit)
    localparam int unsigned CTRL_W  = 8;
    localparam int unsigned CNT_W   = CTRL_W - 1;
    localparam int unsigned EN_BIT  = CTRL_W - 1;
    localparam int unsigned TRG_BIT = CNT_W - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdt_state_t;

    typedef enum logic {
        SRC_WRITE = 1'b0,
        SRC_REARM = 1'b1
    } load_src_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned PRESCALE = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int unsigned PW   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    // tick marks the cycle in which the divider wraps
    assign tick = en && !clr && (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr || !en) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         expire
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_m1;

    assign cnt_m1 = cnt_q - 1'b1;
    assign cnt    = cnt_q;
    // expiry: the top bit goes from 1 to 0 on a decrement
    assign expire = dec && !load && cnt_q[W-1] && !cnt_m1[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_m1;
        end
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hw_mode,
    input  logic      halt_rst_en,
    input  logic      halt_req,
    input  logic      wr_en,
    input  logic      wr_en_bit,
    input  logic      wr_trg_bit,
    input  logic      expire,
    output logic      pre_en,
    output logic      pre_clr,
    output logic      cnt_load,
    output load_src_t cnt_src,
    output logic      rst_pulse,
    output logic      running
);
    wdt_state_t state_q;
    wdt_state_t state_d;

    logic do_force;
    logic do_halt;

    assign do_force = wr_en && !wr_trg_bit;
    assign do_halt  = halt_req && halt_rst_en;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && wr_en_bit) begin
                    state_d = wr_trg_bit ? ST_RUN : ST_FIRE;   // ARM or FORCE
                end
            end
            ST_RUN: begin
                if (do_force || do_halt) begin
                    state_d = ST_FIRE;                         // FORCE / HALT_TRIP
                end else if (expire && !wr_en) begin
                    state_d = ST_FIRE;                         // EXPIRE
                end
            end
            ST_FIRE: begin
                state_d = hw_mode ? ST_RUN : ST_IDLE;          // REARM / RELEASE
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register; the strap picks the state left by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= hw_mode ? ST_RUN : ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the present state
    always_comb begin
        pre_en    = 1'b0;
        pre_clr   = 1'b0;
        cnt_load  = 1'b0;
        cnt_src   = SRC_WRITE;
        rst_pulse = 1'b0;
        running   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pre_clr  = 1'b1;
                cnt_load = wr_en;
            end
            ST_RUN: begin
                pre_en   = 1'b1;
                running  = 1'b1;
                cnt_load = wr_en;
                pre_clr  = wr_en;
            end
            ST_FIRE: begin
                rst_pulse = 1'b1;
                pre_clr   = 1'b1;
                cnt_load  = 1'b1;
                cnt_src   = SRC_REARM;
            end
            default: begin
                pre_clr = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int unsigned PRESCALE = 12288
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_mode,
    input  logic              halt_rst_en,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              halt_req,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic              wdg_rst,
    output logic              wdg_active
);
    logic             pre_en;
    logic             pre_clr;
    logic             tick;
    logic             cnt_load;
    load_src_t        cnt_src;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] load_val;
    logic             expire;
    logic             rst_pulse;
    logic             running;

    assign load_val = (cnt_src == SRC_REARM) ? {CNT_W{1'b1}} : wr_data[CNT_W-1:0];

    wdt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pre_en),
        .clr   (pre_clr),
        .tick  (tick)
    );

    wdt_downcount #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (load_val),
        .dec      (tick),
        .cnt      (cnt_val),
        .expire   (expire)
    );

    wdt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_mode     (hw_mode),
        .halt_rst_en (halt_rst_en),
        .halt_req    (halt_req),
        .wr_en       (wr_en),
        .wr_en_bit   (wr_data[EN_BIT]),
        .wr_trg_bit  (wr_data[TRG_BIT]),
        .expire      (expire),
        .pre_en      (pre_en),
        .pre_clr     (pre_clr),
        .cnt_load    (cnt_load),
        .cnt_src     (cnt_src),
        .rst_pulse   (rst_pulse),
        .running     (running)
    );

    assign ctrl_rd    = {running, cnt_val};
    assign wdg_rst    = rst_pulse;
    assign wdg_active = running;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_mode,
    input logic       halt_rst_en,
    input logic       wr_en,
    input logic [1:0] wr_ctl,
    input logic       halt_req,
    input logic [6:0] cnt_rd,
    input logic       wdg_rst,
    input logic       wdg_active
);
    assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_rst |=> !wdg_rst);

    assert_sticky_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_active |=> (wdg_active || wdg_rst));

    assert_force_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_active && wr_en && !wr_ctl[0]) |=> wdg_rst);

    assert_halt_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_active && halt_req && halt_rst_en) |=> wdg_rst);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdg_active && !wdg_rst && !(wr_en && wr_ctl[1])) |=> (!wdg_active && !wdg_rst));

    assert_release_sw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_rst && !hw_mode) |=> (!wdg_active && cnt_rd == 7'h7F));

    assert_rearm_hw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_rst && hw_mode) |=> (wdg_active && cnt_rd == 7'h7F));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_active && !wr_en) |=>
            (cnt_rd == $past(cnt_rd) || cnt_rd == $past(cnt_rd) - 7'd1));
endmodule

bind wdt_timer wdt_timer_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_mode     (hw_mode),
    .halt_rst_en (halt_rst_en),
    .wr_en       (wr_en),
    .wr_ctl      (wr_data[7:6]),
    .halt_req    (halt_req),
    .cnt_rd      (ctrl_rd[6:0]),
    .wdg_rst     (wdg_rst),
    .wdg_active  (wdg_active)
);

// File: tb/wdt_timer_tb_top.sv
`timescale 1ns/1ps
module wdt_timer_tb_top;
    localparam int unsigned PRE  = 16;
    localparam int unsigned NVEC = 5;
    // stimulus control byte and expected timeout in cycles: (low6 + 1) * PRE
    localparam logic [7:0]  VEC_WR [NVEC] = '{8'hC0, 8'hC1, 8'hC5, 8'hD0, 8'hFF};
    localparam int unsigned VEC_T  [NVEC] = '{1*PRE, 2*PRE, 6*PRE, 17*PRE, 64*PRE};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_mode = 1'b0;
    logic       halt_rst_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       halt_req = 1'b0;
    logic [7:0] ctrl_rd;
    logic       wdg_rst;
    logic       wdg_active;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    wdt_timer #(.PRESCALE(PRE)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_mode     (hw_mode),
        .halt_rst_en (halt_rst_en),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .halt_req    (halt_req),
        .ctrl_rd     (ctrl_rd),
        .wdg_rst     (wdg_rst),
        .wdg_active  (wdg_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic hw);
        @(negedge clk);
        rst_n   = 1'b0;
        hw_mode = hw;
        wr_en   = 1'b0;
        halt_req = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    // waits n-1 cycles expecting silence, then one cycle expecting the pulse
    task automatic expect_fire(input int unsigned n, input string req);
        bit early = 0;
        for (int i = 1; i < int'(n); i++) begin
            step();
            if (wdg_rst) early = 1;
        end
        chk(!early, {req, " no early reset"}, early, 0);
        step();
        chk(wdg_rst == 1'b1, {req, " reset on exact cycle"}, wdg_rst, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired, all requirements: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Vector table: timeout length for each control value (R3, R6, R7)
        for (int v = 0; v < int'(NVEC); v++) begin
            do_reset(1'b0);
            do_write(VEC_WR[v]);
            chk(wdg_active == 1'b1, "R2 enable by write", wdg_active, 1);
            expect_fire(VEC_T[v], "R3");
            step();
            chk(wdg_rst == 1'b0, "R6 single-cycle pulse", wdg_rst, 0);
            chk(ctrl_rd == 8'h7F, "R7 sw release to idle", ctrl_rd, 8'h7F);
        end

        // R1 reset state
        do_reset(1'b0);
        chk(ctrl_rd == 8'h7F && !wdg_active && !wdg_rst, "R1 reset state", ctrl_rd, 8'h7F);

        // R10 disabled write loads counter only
        do_write(8'h55);
        chk(ctrl_rd == 8'h55, "R10 counter loaded while disabled", ctrl_rd, 8'h55);
        begin
            bit seen = 0;
            for (int i = 0; i < 600; i++) begin
                step();
                if (wdg_rst || wdg_active) seen = 1;
            end
            chk(!seen, "R10 no countdown while disabled", seen, 0);
        end
        chk(ctrl_rd == 8'h55, "R10 counter held", ctrl_rd, 8'h55);

        // R2/R4 sticky enable and refresh with bit 7 clear
        do_write(8'hC1);
        begin
            bit seen = 0;
            for (int r = 0; r < 10; r++) begin
                for (int i = 0; i < int'(PRE) + 8; i++) begin
                    step();
                    if (wdg_rst) seen = 1;
                end
                do_write(8'h41);
                if (wdg_rst) seen = 1;
            end
            chk(!seen, "R4 refresh keeps reset low", seen, 0);
        end
        chk(wdg_active == 1'b1 && ctrl_rd[7], "R2 enable sticky against bit7=0", ctrl_rd, 8'hC1);
        expect_fire(2 * PRE, "R4 reload then timeout");

        // R3 readback of the decrementing counter
        do_reset(1'b0);
        do_write(8'hC5);
        repeat (3 * PRE) step();
        chk(ctrl_rd == 8'hC2, "R3 counter readback after 3 periods", ctrl_rd, 8'hC2);

        // R5 forced reset while running and from disabled
        do_write(8'h80);
        chk(wdg_rst == 1'b1, "R5 force 0x80 while running", wdg_rst, 1);
        step();
        chk(!wdg_rst && !wdg_active, "R5/R6 pulse ends, idle", wdg_active, 0);
        do_write(8'h80);
        chk(wdg_rst == 1'b1, "R5 force 0x80 from disabled", wdg_rst, 1);

        // R9 halt handling
        do_reset(1'b0);
        halt_req = 1'b1;
        halt_rst_en = 1'b1;
        begin
            bit seen = 0;
            for (int i = 0; i < 10; i++) begin
                step();
                if (wdg_rst) seen = 1;
            end
            chk(!seen, "R9 halt ignored while disabled", seen, 0);
        end
        halt_req = 1'b0;
        do_write(8'hFF);
        halt_rst_en = 1'b0;
        halt_req = 1'b1;
        begin
            bit seen = 0;
            for (int i = 0; i < 10; i++) begin
                step();
                if (wdg_rst) seen = 1;
            end
            chk(!seen && wdg_active, "R9 halt ignored without permission", seen, 0);
        end
        halt_rst_en = 1'b1;
        step();
        chk(wdg_rst == 1'b1, "R9 permitted halt trips reset", wdg_rst, 1);
        halt_req = 1'b0;
        halt_rst_en = 1'b0;

        // R8/R7 hardware mode
        do_reset(1'b1);
        chk(wdg_active && ctrl_rd == 8'hFF, "R8 active from reset release", ctrl_rd, 8'hFF);
        expect_fire(64 * PRE, "R8");
        step();
        chk(wdg_active && ctrl_rd == 8'hFF, "R7 hw rearm after reset request", ctrl_rd, 8'hFF);
        expect_fire(64 * PRE, "R7 hw second timeout");

        do_reset(1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule